// File: doc/BRIEF.md
# CORDIC Sine Synthesizer

This block is a numerically controlled sine source. It has a 32-bit phase accumulator that advances by a frequency tuning word on every clock. The top 16 bits of the accumulator, plus a 16-bit phase offset, form the instantaneous phase. A fully pipelined CORDIC rotator turns that phase into a sine value. No waveform memory is used. The rotator works only on the first quadrant. The two top phase bits select the quadrant and restore the symmetry. The rotator's x input is preloaded with the inverse of the rotation gain, so no gain-correction multiply follows it.

The sine value is multiplied by a 16-bit unsigned amplitude word. The product is rounded and clipped to a symmetric 16-bit signed sample. One sample leaves the block on every clock.

A controller updates the three control words through a small write port. Each write lands in a staging copy. A single update strobe moves all three staging copies into the working set in the same cycle. The accumulator is never cleared by an update, so frequency and phase changes keep the waveform continuous.

Top module: `cordic_nco`

## Requirements
- R1: After synchronous reset, the frequency, offset and amplitude words are zero, the accumulator is zero, and `dout` is 0.
- R2: A write changes only a staging copy. The output keeps its value until `upd` is pulsed.
- R3: While `upd` is high at a clock edge, all three staging copies become active together at that edge.
- R4: With a zero tuning word and an active offset P, `dout` settles to A·sin(2πP/65536)/2 within 3 LSB, where A is the amplitude word. This holds in all four quadrants.
- R5: The accumulator grows by the active tuning word on every clock. The phase register holds the accumulator's top 16 bits plus the offset. `dout` after clock edge n reflects the phase register value after edge n−20, which is 21 edges after the accumulator value.
- R6: With an amplitude word of 0, `dout` is exactly 0.
- R7: The output is clipped to ±32767 and never equals −32768. With amplitude 0xFFFF, the sample at 90° lies in 32765..32767.
- R8: The write select is `wr_sel`. The value 0 selects the tuning word (32 bits). The value 1 selects the offset (`wr_data[15:0]`). The value 2 selects the amplitude (`wr_data[15:0]`). The value 3 writes nothing.
- R9: A new tuning word applied with `upd` continues from the current accumulator value, without a reset or a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a staging copy |
| wr_sel | input | 2 | Staging copy select (0 tuning, 1 offset, 2 amplitude, 3 none) |
| wr_data | input | 32 | Write data |
| upd | input | 1 | Move all staging copies into the active set |
| dout | output | 16 | Signed sine sample, one per clock |

## Verification
A wrong quadrant decode or a wrong arctangent constant shows up as a wrong static sample. The bench sweeps 64 offsets over all quadrants, at three amplitudes. Such an error appears 21 cycles after the offset becomes active. An accumulator or alignment fault shows as a phase drift against a bench-side accumulator model. That model is compared on every cycle of a running tone. A staging leak shows as an output change before the update strobe. Each of these faults appears within one pipeline latency.

// File: rtl/nco_pkg.sv
package nco_pkg;
  // Fraction bits of the rotator's fixed-point values (1.0 = 2**ROT_FRAC).
  localparam int ROT_FRAC = 20;
  localparam int ROT_W    = ROT_FRAC + 2;

  // Inverse CORDIC gain, about 0.60725.
  localparam logic signed [ROT_W-1:0] INV_GAIN = 22'sd636751;
  // Half pi in radians at the same scale.
  localparam logic [ROT_W-1:0] HALF_PI = 22'd1647099;

  typedef enum logic [1:0] {
    SEL_FREQ  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_AMP   = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;

  // atan(2**-k) in radians, scaled by 2**ROT_FRAC.
  function automatic logic signed [ROT_W-1:0] atan_step(input int k);
    case (k)
      0: return 22'sd823550;
      1: return 22'sd486170;
      2: return 22'sd256879;
      3: return 22'sd130396;
      4: return 22'sd65451;
      5: return 22'sd32757;
      6: return 22'sd16383;
      default:
        return (k <= ROT_FRAC) ? ROT_W'(1 << (ROT_FRAC - k)) : '0;
    endcase
  endfunction
endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int FW = 32,
  parameter int PW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [FW-1:0] wr_data,
  input  logic          upd,
  output logic [FW-1:0] ftw_q,
  output logic [PW-1:0] pow_q,
  output logic [AW-1:0] amp_q
);
  logic [FW-1:0] ftw_s;
  logic [PW-1:0] pow_s;
  logic [AW-1:0] amp_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_s <= '0;
      pow_s <= '0;
      amp_s <= '0;
    end else if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_FREQ:  ftw_s <= wr_data;
        SEL_PHASE: pow_s <= wr_data[PW-1:0];
        SEL_AMP:   amp_s <= wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_q <= '0;
      pow_q <= '0;
      amp_q <= '0;
    end else if (upd) begin
      ftw_q <= ftw_s;
      pow_q <= pow_s;
      amp_q <= amp_s;
    end
  end

  // R2
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(ftw_q) && $stable(pow_q) && $stable(amp_q)));
endmodule

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int FW = 32,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] ftw,
  input  logic [PW-1:0] pow,
  output logic [PW-1:0] phase
);
  logic [FW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      phase <= '0;
    end else begin
      acc_q <= acc_q + ftw;
      phase <= acc_q[FW-1 -: PW] + pow;
    end
  end
endmodule

// File: rtl/nco_cordic.sv
module nco_cordic
  import nco_pkg::*;
#(
  parameter int PW     = 16,
  parameter int STAGES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PW-1:0]           phase,
  output logic signed [ROT_W-1:0] sine
);
  localparam int FRAC_BITS = PW - 2;
  localparam logic signed [ROT_W-1:0] ZTOL = ROT_W'(1 << (ROT_FRAC - STAGES + 3));

  // Quadrant fold: map the lower phase bits to radians in [0, pi/2).
  logic [FRAC_BITS+ROT_W-1:0] zprod;
  logic signed [ROT_W-1:0]    x0_q, y0_q, z0_q;
  logic [1:0]                 q0_q;

  assign zprod = phase[FRAC_BITS-1:0] * HALF_PI;

  always_ff @(posedge clk) begin
    if (rst) begin
      x0_q <= '0;
      y0_q <= '0;
      z0_q <= '0;
      q0_q <= '0;
    end else begin
      x0_q <= INV_GAIN;
      y0_q <= '0;
      z0_q <= $signed(zprod[FRAC_BITS +: ROT_W]);
      q0_q <= phase[PW-1 -: 2];
    end
  end

  // R4
  angle_range_chk: assert property (@(posedge clk) disable iff (rst)
    (z0_q >= 0) && (z0_q < $signed(HALF_PI)));

  for (genvar i = 0; i < STAGES; i++) begin : g_st
    localparam logic signed [ROT_W-1:0] ANG = atan_step(i);
    logic signed [ROT_W-1:0] x_in, y_in, z_in;
    logic [1:0]              q_in;
    logic signed [ROT_W-1:0] x_q, y_q, z_q;
    logic [1:0]              q_q;

    if (i == 0) begin : g_head
      assign x_in = x0_q;
      assign y_in = y0_q;
      assign z_in = z0_q;
      assign q_in = q0_q;
    end else begin : g_tail
      assign x_in = g_st[i-1].x_q;
      assign y_in = g_st[i-1].y_q;
      assign z_in = g_st[i-1].z_q;
      assign q_in = g_st[i-1].q_q;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        x_q <= '0;
        y_q <= '0;
        z_q <= '0;
        q_q <= '0;
      end else begin
        q_q <= q_in;
        if (z_in[ROT_W-1]) begin
          x_q <= x_in + (y_in >>> i);
          y_q <= y_in - (x_in >>> i);
          z_q <= z_in + ANG;
        end else begin
          x_q <= x_in - (y_in >>> i);
          y_q <= y_in + (x_in >>> i);
          z_q <= z_in - ANG;
        end
      end
    end
  end

  logic signed [ROT_W-1:0] x_end, y_end, z_end;
  logic [1:0]              q_end;
  assign x_end = g_st[STAGES-1].x_q;
  assign y_end = g_st[STAGES-1].y_q;
  assign z_end = g_st[STAGES-1].z_q;
  assign q_end = g_st[STAGES-1].q_q;

  // R4
  conv_chk: assert property (@(posedge clk) disable iff (rst)
    (z_end < ZTOL) && (z_end > -ZTOL));

  // Quadrant unfold: pick sine or cosine and apply the sign.
  always_ff @(posedge clk) begin
    if (rst) sine <= '0;
    else begin
      case (q_end)
        2'd0:    sine <= y_end;
        2'd1:    sine <= x_end;
        2'd2:    sine <= -y_end;
        default: sine <= -x_end;
      endcase
    end
  end
endmodule

// File: rtl/nco_scale.sv
module nco_scale
  import nco_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ROT_W-1:0] s,
  input  logic [AW-1:0]           amp,
  output logic signed [DW-1:0]    dout
);
  localparam int PRW = ROT_W + AW + 1;
  localparam logic signed [PRW-1:0] HALF = PRW'(1) <<< ROT_FRAC;
  localparam logic signed [PRW-1:0] MAXV = PRW'((1 << (DW-1)) - 1);
  localparam logic signed [PRW-1:0] MINV = -MAXV;

  logic signed [PRW-1:0] prod_q, rnd;

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= s * $signed({1'b0, amp});
  end

  assign rnd = (prod_q + HALF) >>> (ROT_FRAC + 1);

  always_ff @(posedge clk) begin
    if (rst)              dout <= '0;
    else if (rnd > MAXV)  dout <= MAXV[DW-1:0];
    else if (rnd < MINV)  dout <= MINV[DW-1:0];
    else                  dout <= rnd[DW-1:0];
  end

  // R6
  amp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(amp) == '0) |=> (dout == '0));

  // R7
  out_sym_chk: assert property (@(posedge clk) disable iff (rst)
    dout != {1'b1, {(DW-1){1'b0}}});
endmodule

// File: rtl/cordic_nco.sv
module cordic_nco
  import nco_pkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int AMP_W   = 16,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [FREQ_W-1:0]       wr_data,
  input  logic                    upd,
  output logic signed [OUT_W-1:0] dout
);
  logic [FREQ_W-1:0]       ftw;
  logic [PHASE_W-1:0]      pow, phase;
  logic [AMP_W-1:0]        amp;
  logic signed [ROT_W-1:0] sine;

  nco_ctrl #(.FW(FREQ_W), .PW(PHASE_W), .AW(AMP_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd(upd), .ftw_q(ftw), .pow_q(pow), .amp_q(amp)
  );

  nco_phase #(.FW(FREQ_W), .PW(PHASE_W)) u_phase (
    .clk(clk), .rst(rst), .ftw(ftw), .pow(pow), .phase(phase)
  );

  nco_cordic #(.PW(PHASE_W), .STAGES(STAGES)) u_cordic (
    .clk(clk), .rst(rst), .phase(phase), .sine(sine)
  );

  nco_scale #(.AW(AMP_W), .DW(OUT_W)) u_scale (
    .clk(clk), .rst(rst), .s(sine), .amp(amp), .dout(dout)
  );
endmodule

// File: tb/sim_cordic_nco.sv
`timescale 1ns/1ps
module sim_cordic_nco;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, upd = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic signed [15:0] dout;

  always #2.5 clk = ~clk;

  cordic_nco u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .upd(upd), .dout(dout)
  );

  int vectors = 0, miscompares = 0;

  // Bench-side model of the control words and the accumulator.
  logic [31:0] acc_m, ftw_m, sh_ftw;
  logic [15:0] pow_m, sh_pow, amp_m, sh_amp;
  logic [15:0] ph_hist [0:63];
  int n_m = 0;

  function automatic real ideal(int ph, int amp);
    real e;
    e = $sin(2.0 * PI * real'(ph) / 65536.0) * real'(amp) / 2.0;
    if (e > 32767.0) e = 32767.0;
    if (e < -32767.0) e = -32767.0;
    return e;
  endfunction

  task automatic check_eq(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(string req, int ph, int amp);
    real e, d;
    e = ideal(ph, amp);
    d = real'(int'(dout)) - e;
    vectors++;
    if (d > 3.0 || d < -3.0) begin
      miscompares++;
      $display("FAIL %s: phase %0d amp %0d got %0d expected %0d",
               req, ph, amp, int'(dout), int'(e));
    end
  endtask

  task automatic check_range(string req, int lo, int hi);
    vectors++;
    if (int'(dout) < lo || int'(dout) > hi) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, int'(dout), lo, hi);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) begin
      acc_m = '0; ftw_m = '0; pow_m = '0; amp_m = '0;
      sh_ftw = '0; sh_pow = '0; sh_amp = '0; n_m = 0;
    end else begin
      ph_hist[n_m % 64] = acc_m[31:16] + pow_m;
      acc_m = acc_m + ftw_m;
      if (upd) begin ftw_m = sh_ftw; pow_m = sh_pow; amp_m = sh_amp; end
      if (wr_en) begin
        case (wr_sel)
          2'd0: sh_ftw = wr_data;
          2'd1: sh_pow = wr_data[15:0];
          2'd2: sh_amp = wr_data[15:0];
          default: ;
        endcase
      end
      n_m++;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    step();
    wr_en = 1'b0;
  endtask

  task automatic commit();
    upd = 1'b1;
    step();
    upd = 1'b0;
  endtask

  // Output after the last edge matches the phase register 20 edges earlier (R5).
  task automatic stream(string req, int cycles);
    for (int k = 0; k < cycles; k++) begin
      step();
      check_near(req, int'(ph_hist[(n_m - 21) % 64]), int'(amp_m));
    end
  endtask

  task automatic settle_static(int ph, int amp);
    wr(2'd1, 32'(ph));
    wr(2'd2, 32'(amp));
    commit();
    repeat (22) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int held;
    repeat (3) step();
    rst = 1'b0;

    // R1: reset state
    for (int k = 0; k < 25; k++) begin
      step();
      check_eq("R1", int'(dout), 0);
    end

    // R4: static sweep of offsets over all quadrants, three amplitudes
    for (int p = 0; p < 64; p++) begin
      for (int a = 0; a < 3; a++) begin
        int amp;
        amp = (a == 0) ? 65535 : (a == 1) ? 20000 : 777;
        settle_static(p * 1024 + 37, amp);
        check_near("R4", p * 1024 + 37, amp);
      end
    end

    // R7: full-scale corners
    settle_static(16'h4000, 65535); check_range("R7", 32765, 32767);
    settle_static(16'hC000, 65535); check_range("R7", -32767, -32765);
    settle_static(16'h0000, 65535); check_range("R7", -2, 2);
    settle_static(16'h8000, 65535); check_range("R7", -2, 2);

    // R2: staged writes do not reach the output before upd
    settle_static(16'h2000, 30000);
    held = int'(dout);
    wr(2'd2, 32'd0);
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, 32'h0010_0000);
    for (int k = 0; k < 25; k++) begin
      step();
      check_eq("R2", int'(dout), held);
    end

    // R6, R8: amplitude zero gives exact zero; select 3 did not write the amplitude
    commit();
    repeat (22) step();
    for (int k = 0; k < 20; k++) begin
      step();
      check_eq("R6", int'(dout), 0);
      check_eq("R8", int'(dout), 0);
    end

    // Running tone at a fixed amplitude; the model keeps phase alignment
    wr(2'd2, 32'd40000);
    commit();
    repeat (25) step();
    stream("R5", 30);

    // R3: new tuning word and offset staged, then made active together
    wr(2'd0, 32'h0123_4567);
    wr(2'd1, 32'h0000_3000);
    stream("R3", 30);
    commit();
    stream("R5", 200);

    // R9: retuning continues from the current accumulator value
    wr(2'd0, 32'h00AB_CDEF);
    commit();
    stream("R9", 200);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule